// File: doc/BRIEF.md
# System Control Port for Tone Channel Gating

This block is an 8-bit control and status port. Software writes it to set two things. One is the count-enable (gate) of the third interval-timer channel. The other is an enable that passes that channel's output on to a speaker line.

A read returns a status byte. The byte combines:
- the two stored control bits,
- the live output level of the timer channel, taken from an input pin,
- a refresh bit that flips at a fixed interval, generated inside the block from a clock-cycle count.

The two gate levels of the other timer channels are fixed high. The speaker line is the timer output masked by the enable.

Top module: `sysctl_port`

## Requirements
- R1: When `wr_en` is high at a clock edge, `wr_data[0]` is stored as the gate level and `wr_data[1]` as the speaker enable; `wr_data[7:2]` is ignored.
- R2: Reset clears both stored bits, so `gate2` is low after reset; `gate0` and `gate1` are always high.
- R3: `rd_data[0]` equals the stored gate level and `rd_data[1]` equals the stored speaker enable. Both reflect a write from the clock edge after that write.
- R4: `rd_data[5]` equals `out2` combinationally, with no register delay.
- R5: `rd_data[4]` is a refresh toggle. It is low after reset and inverts once every `REFRESH_CYCLES` clock cycles. The first inversion comes `REFRESH_CYCLES` edges after reset is released.
- R6: `rd_data[7:6]` and `rd_data[3:2]` always read zero.
- R7: `spk_out` equals `out2` AND the stored speaker enable, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Status byte |
| out2 | input | 1 | Output level of timer channel 2 |
| gate0 | output | 1 | Gate of channel 0, held high |
| gate1 | output | 1 | Gate of channel 1, held high |
| gate2 | output | 1 | Gate of channel 2 |
| spk_en | output | 1 | Stored speaker data enable |
| spk_out | output | 1 | Speaker drive |

## Verification
A corrupted stored control bit appears in the same cycle at three places: `gate2` or `spk_en`, the matching low bits of `rd_data`, and `spk_out` when `out2` is high. The bench compares all of these after every random write. A refresh divider that miscounts shows up as bit 4 flipping at the wrong edge. The bench checks bit 4 against its own cycle count on every cycle.

// File: rtl/sysctl_port.sv
module sysctl_port #(
  parameter int REFRESH_CYCLES = 15,
  localparam int CW = $clog2(REFRESH_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       out2,
  output logic       gate0,
  output logic       gate1,
  output logic       gate2,
  output logic       spk_en,
  output logic       spk_out
);

  logic          gate_q, spk_q, refresh_q;
  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      spk_q  <= 1'b0;
    end else if (wr_en) begin
      gate_q <= wr_data[0];
      spk_q  <= wr_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      refresh_q <= 1'b0;
    end else if (div_q == CW'(REFRESH_CYCLES - 1)) begin
      div_q     <= '0;
      refresh_q <= ~refresh_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign gate0   = 1'b1;
  assign gate1   = 1'b1;
  assign gate2   = gate_q;
  assign spk_en  = spk_q;
  assign spk_out = out2 & spk_q;
  assign rd_data = {2'b00, out2, refresh_q, 2'b00, spk_q, gate_q};

endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       out2,
  input logic       gate0,
  input logic       gate1,
  input logic       gate2,
  input logic       spk_en,
  input logic       spk_out
);
  AST_WRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> gate2 == $past(wr_data[0])); // R1
  AST_WRITE_SPK: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> spk_en == $past(wr_data[1])); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(gate2) && $stable(spk_en)); // R1
  AST_RESET_GATE: assert property (@(posedge clk) !rst_n |=> !gate2 && !spk_en); // R2
  AST_FIXED_GATES: assert property (@(posedge clk) disable iff (!rst_n) gate0 && gate1); // R2
  AST_READ_CTRL: assert property (@(posedge clk) disable iff (!rst_n) rd_data[1:0] == {spk_en, gate2}); // R3
  AST_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n) rd_data[5] == out2); // R4
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n) rd_data[7:6] == 2'b00 && rd_data[3:2] == 2'b00); // R6
  AST_SPK_AND: assert property (@(posedge clk) disable iff (!rst_n) spk_out == (out2 & spk_en)); // R7
endmodule

bind sysctl_port sysctl_port_chk u_chk (.*);

// File: tb/tb_sysctl_port.sv
`timescale 1ns/1ps
module tb_sysctl_port;
  localparam int RC = 15;
  logic clk = 0, rst_n = 0, wr_en = 0, out2 = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic gate0, gate1, gate2, spk_en, spk_out;
  int checks = 0, fails = 0;
  logic eg = 0, es = 0, er = 0;
  int cyc = 0;
  logic running = 0;

  sysctl_port #(.REFRESH_CYCLES(RC)) dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_rd(logic g, logic s, logic r, logic o);
    return {2'b00, o, r, 2'b00, s, g};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0; er <= 0;
    end else if (cyc == RC - 1) begin
      cyc <= 0; er <= ~er;
    end else cyc <= cyc + 1;
  end

  always @(negedge clk) if (running) begin
    chk("R5 refresh bit", {7'd0, rd_data[4]}, {7'd0, er});
    chk("R3 R4 R6 status byte", rd_data, exp_rd(eg, es, er, out2));
    chk("R7 spk_out", {7'd0, spk_out}, {7'd0, out2 & es});
    chk("R2 fixed gates", {6'd0, gate1, gate0}, 8'h03);
  end

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(posedge clk); #1;
    eg = d[0]; es = d[1];
    wr_en = 0; wr_data = $urandom;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R2 reset gate2", {6'd0, spk_en, gate2}, 8'h00);
    chk("R5 reset refresh", {7'd0, rd_data[4]}, 8'h00);
    running = 1;
    wr(8'hFD); chk("R1 upper bits ignored", {6'd0, spk_en, gate2}, 8'h01);
    wr(8'h02); chk("R1 spk only", {6'd0, spk_en, gate2}, 8'h02);
    out2 = 1; #1 chk("R4 R7 live out", {rd_data[5], 6'd0, spk_out}, 8'h81);
    wr(8'h03);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) == 0) wr($urandom);
      else @(posedge clk);
      #2 out2 = $urandom;
    end
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule